// File: doc/BRIEF.md
# Multi-Cause Stall Tracker

This block decides whether a cache front end must hold off its request port. Any of several independent reasons can require a stall, for example a full miss-handling queue, a full write buffer or an outstanding snoop reply. Each reason has a small index. A requester raises a reason with a set strobe and drops it with a clear strobe. The port stays held for as long as at least one reason is active.

The block also keeps two statistics for each reason. The first counts stall episodes, charged to the reason that started the stall from the idle state. The second accumulates stalled cycles, charged to the reason whose clear ends the stall. Time comes from a free-running cycle count supplied by the surrounding logic. Elapsed time is measured modulo the width of that count. Both statistics saturate at their maximum and are presented as flat output vectors.

Top module: `blk_stall_tracker`

## Requirements
- R1: After a synchronous active-low reset, no reason is active, `port_hold` is low and every episode and cycle counter reads zero.
- R2: A set strobe for reason k, arriving when no reason is active, adds one to the episode counter of reason k (bits [32k+31:32k] of `episode_cnt`), stores the current `cycle_now` as the stall start and raises `port_hold`. All three effects are visible after the next rising clock edge.
- R3: A set strobe arriving while any reason is already active, including the same reason again, only marks that reason active. No counter changes and the stored stall start is kept.
- R4: Clearing an active reason while another reason stays active keeps `port_hold` high and changes no counter.
- R5: Clearing the last active reason lowers `port_hold` and adds (`cycle_now` minus the stored start) to the cycle counter of the clearing reason (bits [32k+31:32k] of `stall_cycles`), whichever reason started the stall.
- R6: When a set strobe and a clear strobe arrive in the same cycle, the set takes effect first and the clear second. A set and clear of the same reason while idle therefore counts one episode and charges zero cycles.
- R7: A clear for a reason that is not active has no effect. When no reason is active it charges nothing.
- R8: Every counter is 32 bits wide and saturates at 0xFFFFFFFF instead of wrapping.
- R9: The elapsed time is computed modulo 2^32, so a stall that spans a wrap of `cycle_now` is charged the true cycle distance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| set_vld | input | 1 | Set strobe: marks a reason active |
| set_idx | input | 3 | Reason index for the set strobe |
| clr_vld | input | 1 | Clear strobe: marks a reason inactive |
| clr_idx | input | 3 | Reason index for the clear strobe |
| cycle_now | input | 32 | Free-running cycle count |
| port_hold | output | 1 | High while any reason is active |
| episode_cnt | output | 256 | Eight 32-bit episode counters, reason k in bits [32k+31:32k] |
| stall_cycles | output | 256 | Eight 32-bit stalled-cycle totals, reason k in bits [32k+31:32k] |

## Verification
Every result is registered once. A strobe sampled on a rising edge changes `port_hold` and the counters on that same edge, so each result is due exactly one edge after its stimulus. The bench drives strobes and `cycle_now` on the falling edge, lets one rising edge pass, and reads the outputs on the following falling edge. No check depends on the order of processes at an edge. The scenarios use start and end cycle values whose expected charge is known in advance, including a wrap of the cycle count and a sum that overflows 32 bits.

// File: rtl/blk_pkg.sv
// Shared defaults for the stall tracker.
// Assumes: the reason count is a power of two, and the cycle count is no wider than a counter.
package blk_pkg;
    localparam int unsigned DEF_CAUSES = 8;
    localparam int unsigned DEF_CNT_W  = 32;
    localparam int unsigned DEF_CYC_W  = 32;
endpackage

// File: rtl/blk_sat_acc.sv
// Saturating accumulator: adds add_val when add_en is high and sticks at all ones.
// Assumes: add_val is already sized to the counter width.
module blk_sat_acc #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         add_en,
    input  logic [W-1:0] add_val,
    output logic [W-1:0] cnt
);
    logic [W:0]   sum_ext;
    logic [W-1:0] cnt_q;

    // Widened sum, so that the carry shows an overflow.
    always_comb sum_ext = {1'b0, cnt_q} + {1'b0, add_val};

    // Counter register, clamped at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (add_en) cnt_q <= sum_ext[W] ? {W{1'b1}} : sum_ext[W-1:0];
    end

    assign cnt = cnt_q;

    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        add_en |=> cnt_q >= $past(cnt_q));
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !add_en |=> $stable(cnt_q));
endmodule

// File: rtl/blk_cause_mask.sv
// Keeps the mask of active reasons and the stall start cycle.
// Emits one-hot strobes: an episode strobe for the reason that starts a stall,
// and a charge strobe for the reason that ends it, with the elapsed cycles.
// Assumes: a set and a clear in the same cycle are applied in that order.
module blk_cause_mask #(
    parameter int unsigned N     = 8,
    parameter int unsigned CYC_W = 32,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_vld,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             clr_vld,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [CYC_W-1:0] cycle_now,
    output logic             blocked,
    output logic [N-1:0]     ep_inc,
    output logic [N-1:0]     chg_inc,
    output logic [CYC_W-1:0] elapsed
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0]     mask_q, set_flag, clr_flag, mid_mask, nxt_mask;
    logic [CYC_W-1:0] start_q, base_cyc;
    logic             starting, ending;

    // Apply the set first and the clear second.
    always_comb begin
        set_flag = set_vld ? (ONE << set_idx) : '0;
        clr_flag = clr_vld ? (ONE << clr_idx) : '0;
        mid_mask = mask_q | set_flag;
        nxt_mask = mid_mask & ~clr_flag;
        starting = set_vld && (mask_q == '0);
        ending   = (mid_mask != '0) && (nxt_mask == '0);
    end

    // Stall start for the elapsed count: this cycle if the stall opens now.
    always_comb begin
        base_cyc = starting ? cycle_now : start_q;
        elapsed  = cycle_now - base_cyc;
        ep_inc   = starting ? set_flag : '0;
        chg_inc  = ending ? clr_flag : '0;
    end

    // Mask and start-cycle registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            start_q <= '0;
        end else begin
            mask_q <= nxt_mask;
            if (starting) start_q <= cycle_now;
        end
    end

    assign blocked = |mask_q;

    a_r2_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vld && mask_q == '0 && !(clr_vld && clr_idx == set_idx)) |=> blocked);
    a_r3_start_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q != '0) |=> $stable(start_q));
    a_r4_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && !set_vld && $countones(mask_q) > 1) |=> blocked);
    a_r5_unblocks: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && !set_vld && mask_q == (ONE << clr_idx)) |=> !blocked);
endmodule

// File: rtl/blk_stall_tracker.sv
// Top: holds the request port while any reason is active, and keeps a
// saturating episode counter and a stalled-cycle total for each reason.
// Assumes: cycle_now advances freely and may wrap.
module blk_stall_tracker #(
    parameter int unsigned N_CAUSE = blk_pkg::DEF_CAUSES,
    parameter int unsigned CNT_W   = blk_pkg::DEF_CNT_W,
    parameter int unsigned CYC_W   = blk_pkg::DEF_CYC_W,
    localparam int unsigned IDX_W  = $clog2(N_CAUSE)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_vld,
    input  logic [IDX_W-1:0]         set_idx,
    input  logic                     clr_vld,
    input  logic [IDX_W-1:0]         clr_idx,
    input  logic [CYC_W-1:0]         cycle_now,
    output logic                     port_hold,
    output logic [N_CAUSE*CNT_W-1:0] episode_cnt,
    output logic [N_CAUSE*CNT_W-1:0] stall_cycles
);
    logic [N_CAUSE-1:0] ep_inc, chg_inc;
    logic [CYC_W-1:0]   elapsed;
    logic [CNT_W-1:0]   elapsed_ext;

    blk_cause_mask #(.N(N_CAUSE), .CYC_W(CYC_W)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .set_vld(set_vld), .set_idx(set_idx),
        .clr_vld(clr_vld), .clr_idx(clr_idx),
        .cycle_now(cycle_now),
        .blocked(port_hold),
        .ep_inc(ep_inc), .chg_inc(chg_inc), .elapsed(elapsed)
    );

    // Widen the elapsed count to the counter width.
    always_comb elapsed_ext = CNT_W'(elapsed);

    for (genvar k = 0; k < N_CAUSE; k++) begin : g_cause
        blk_sat_acc #(.W(CNT_W)) u_ep (
            .clk(clk), .rst_n(rst_n),
            .add_en(ep_inc[k]), .add_val(CNT_W'(1)),
            .cnt(episode_cnt[k*CNT_W +: CNT_W])
        );
        blk_sat_acc #(.W(CNT_W)) u_cyc (
            .clk(clk), .rst_n(rst_n),
            .add_en(chg_inc[k]), .add_val(elapsed_ext),
            .cnt(stall_cycles[k*CNT_W +: CNT_W])
        );
    end

    a_r2_one_episode: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ep_inc));
    a_r5_one_charge: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chg_inc));
endmodule

// File: tb/blk_stall_tracker_bench.sv
module blk_stall_tracker_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         set_vld = 1'b0, clr_vld = 1'b0;
    logic [2:0]   set_idx = '0, clr_idx = '0;
    logic [31:0]  cycle_now = '0;
    logic         port_hold;
    logic [255:0] episode_cnt, stall_cycles;
    int           n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    blk_stall_tracker u_blk_stall_tracker (
        .clk(clk), .rst_n(rst_n),
        .set_vld(set_vld), .set_idx(set_idx),
        .clr_vld(clr_vld), .clr_idx(clr_idx),
        .cycle_now(cycle_now),
        .port_hold(port_hold),
        .episode_cnt(episode_cnt), .stall_cycles(stall_cycles)
    );

    function automatic logic [31:0] ep(input int k);
        return episode_cnt[k*32 +: 32];
    endfunction
    function automatic logic [31:0] sc(input int k);
        return stall_cycles[k*32 +: 32];
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one cycle of strobes at the falling edge; results are read one falling edge later.
    task automatic step(input logic sv, input logic [2:0] si, input logic cv,
                        input logic [2:0] ci, input logic [31:0] cyc);
        @(negedge clk);
        set_vld = sv; set_idx = si; clr_vld = cv; clr_idx = ci; cycle_now = cyc;
        @(negedge clk);
        set_vld = 1'b0; clr_vld = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 hold", {31'b0, port_hold}, 0);
        for (int k = 0; k < 8; k++) begin
            check("R1 episodes", ep(k), 0);
            check("R1 cycles", sc(k), 0);
        end
    endtask

    task automatic t_nested();
        step(1, 2, 0, 0, 100);
        check("R2 episode", ep(2), 1);
        check("R2 hold", {31'b0, port_hold}, 1);
        step(1, 5, 0, 0, 105);
        step(1, 2, 0, 0, 110);
        check("R3 no episode 5", ep(5), 0);
        check("R3 no episode 2", ep(2), 1);
        step(0, 0, 1, 2, 120);
        check("R4 hold", {31'b0, port_hold}, 1);
        check("R4 no charge", sc(2), 0);
        step(0, 0, 1, 5, 130);
        check("R5 charge to clearer", sc(5), 30);
        check("R5 starter uncharged", sc(2), 0);
        check("R5 released", {31'b0, port_hold}, 0);
    endtask

    task automatic t_idle_clear();
        step(0, 0, 1, 4, 200);
        check("R7 idle clear hold", {31'b0, port_hold}, 0);
        check("R7 idle clear charge", sc(4), 0);
        step(1, 1, 0, 0, 210);
        step(0, 0, 1, 6, 215);
        check("R7 stray clear hold", {31'b0, port_hold}, 1);
        check("R7 stray clear charge", sc(6), 0);
        step(0, 0, 1, 1, 222);
        check("R5 charge 1", sc(1), 12);
    endtask

    task automatic t_same_cycle();
        step(1, 3, 1, 3, 300);
        check("R6 episode", ep(3), 1);
        check("R6 zero charge", sc(3), 0);
        check("R6 hold low", {31'b0, port_hold}, 0);
        step(1, 0, 0, 0, 310);
        step(1, 7, 1, 0, 320);
        check("R6 swap hold", {31'b0, port_hold}, 1);
        check("R6 swap no charge", sc(0), 0);
        check("R6 swap no episode", ep(7), 0);
        step(0, 0, 1, 7, 335);
        check("R6 swap charge", sc(7), 25);
    endtask

    task automatic t_wrap();
        step(1, 4, 0, 0, 32'hFFFF_FFFE);
        step(0, 0, 1, 4, 32'd3);
        check("R9 wrap charge", sc(4), 5);
        check("R9 episode", ep(4), 1);
    endtask

    task automatic t_sat();
        step(1, 6, 0, 0, 0);
        step(0, 0, 1, 6, 32'hFFFF_FFF0);
        check("R8 large charge", sc(6), 32'hFFFF_FFF0);
        step(1, 6, 0, 0, 32'h10);
        step(0, 0, 1, 6, 32'h40);
        check("R8 saturated", sc(6), 32'hFFFF_FFFF);
        step(1, 6, 0, 0, 32'h50);
        step(0, 0, 1, 6, 32'h51);
        check("R8 stays saturated", sc(6), 32'hFFFF_FFFF);
        check("R2 episodes 6", ep(6), 3);
    endtask

    initial begin : watchdog
        #(20 * 5000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nested();
        t_idle_clear();
        t_same_cycle();
        t_wrap();
        t_sat();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule